// File: doc/BRIEF.md
# Addressed Two-Wire Packet Slave

This block is the slave end of a two-wire serial link. One wire carries a bus clock that the master drives. The other wire carries data in both directions. The block samples both wires into its own system clock domain. It frames each packet by counting bus clock rising edges, so no select line is needed. A packet is 32 bits long, sent most significant bit first: an 8-bit address, then an 8-bit command, then 16 data bits.

The block compares the received address with a parameter. When the address matches and command bit 7 is clear, the packet is a write: the block collects the 16 data bits and hands the command and data to local logic with a one-cycle strobe. When the address matches and command bit 7 is set, the packet is a read: the block asks local logic for a 16-bit word, takes over the data line, and shifts the word back to the master. If the address does not match, the block still counts the packet's bits but never answers. If the bus clock stays still for too long, the bit count returns to the start of a packet.

The shared data wire appears as three pins: an input, an output, and an output enable. The enable drives the pad's tristate control.

Top module: `pkt_bus_slave`

## Requirements
- R1: After reset, `bus_dat_oe`, `wr_valid` and `rd_req` are low.
- R2: Bits are captured on each synchronized rising edge of `bus_clk`, most significant bit first. Bits 1 to 8 of a packet are the address, bits 9 to 16 are the command, and bits 17 to 32 are the data.
- R3: When a packet's address equals `DEV_ADDR` and command bit 7 is 0, the block raises `wr_valid` for exactly one system cycle after the 32nd rising edge. During that cycle `wr_cmd` holds the command and `wr_data` holds the 16 data bits.
- R4: A packet whose address differs from `DEV_ADDR` produces no `wr_valid` and no `rd_req`, and `bus_dat_oe` stays low for the whole packet.
- R5: When the address matches and command bit 7 is 1, the block raises `rd_req` for exactly one cycle after the 16th rising edge, with `rd_cmd` holding the command. The block takes the reply from `rd_data` in that same cycle.
- R6: In a matched read, `bus_dat_oe` rises right after the 16th rising edge and stays high until the falling edge that follows the 32nd rising edge. At each of rising edges 17 to 32, `bus_dat_o` presents the next reply bit, most significant bit first, and holds it until the next rising edge.
- R7: If no edge of `bus_clk` is seen for `IDLE_LIMIT` system cycles, the block returns to the first bit of a packet and releases the data line. The next full packet is then handled normally.
- R8: A matched write never enables the data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk | input | 1 | Bus clock from the master (asynchronous) |
| bus_dat_i | input | 1 | Data line as seen at the pad |
| bus_dat_o | output | 1 | Data value driven onto the line during a read |
| bus_dat_oe | output | 1 | Output enable for the data line pad |
| rd_req | output | 1 | One-cycle request for a reply word |
| rd_cmd | output | 8 | Command of the read request |
| rd_data | input | 16 | Reply word from local logic, sampled while `rd_req` is high |
| wr_valid | output | 1 | One-cycle strobe for a completed matched write |
| wr_cmd | output | 8 | Command of the completed write |
| wr_data | output | 16 | Data of the completed write |

## Verification
The hardest case to reach is the idle resynchronization in the middle of a read, when the slave is already driving the line. The bench gets there by sending a matched read header and a few reply bits, then holding the bus clock still. It then checks that the line is released and that the next full packet still decodes correctly. It also sends a packet cut off part way through, followed by a clean write, to show that a misaligned bit count recovers. All other stimulus is a sweep: walking-one data words, a range of commands of both directions, and several addresses that do not match.

// File: rtl/pkt_bus_slave.sv
module pkt_bus_slave #(
  parameter logic [7:0] DEV_ADDR   = 8'h5A,
  parameter int         IDLE_LIMIT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_clk,
  input  logic        bus_dat_i,
  output logic        bus_dat_o,
  output logic        bus_dat_oe,
  output logic        rd_req,
  output logic [7:0]  rd_cmd,
  input  logic [15:0] rd_data,
  output logic        wr_valid,
  output logic [7:0]  wr_cmd,
  output logic [15:0] wr_data
);
  localparam int IW = $clog2(IDLE_LIMIT + 1);

  logic [1:0]    ck_s, dt_s;
  logic          ck_prev;
  logic [4:0]    cnt;
  logic [15:0]   hdr, dsh, rsh;
  logic          rd_act, wr_act;
  logic [IW-1:0] idle;

  wire rise   = ck_s[1] & ~ck_prev;
  wire fall   = ~ck_s[1] & ck_prev;
  wire din    = dt_s[1];
  wire [15:0] hdr_nxt = {hdr[14:0], din};
  wire hit    = hdr_nxt[15:8] == DEV_ADDR;
  wire resync = !rise && !fall && idle == IW'(IDLE_LIMIT - 1);

  assign bus_dat_oe = rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_s    <= '0;
      dt_s    <= '0;
      ck_prev <= 1'b0;
      idle    <= '0;
    end else begin
      ck_s    <= {ck_s[0], bus_clk};
      dt_s    <= {dt_s[0], bus_dat_i};
      ck_prev <= ck_s[1];
      if (rise || fall)            idle <= '0;
      else if (idle != IW'(IDLE_LIMIT)) idle <= idle + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      hdr      <= '0;
      dsh      <= '0;
      rsh      <= '0;
      rd_act   <= 1'b0;
      wr_act   <= 1'b0;
      rd_req   <= 1'b0;
      rd_cmd   <= '0;
      wr_valid <= 1'b0;
      wr_cmd   <= '0;
      wr_data  <= '0;
      bus_dat_o <= 1'b0;
    end else begin
      rd_req   <= 1'b0;
      wr_valid <= 1'b0;
      if (rd_req) rsh <= rd_data;
      if (resync) begin
        cnt    <= '0;
        rd_act <= 1'b0;
        wr_act <= 1'b0;
      end else if (rise) begin
        cnt <= cnt + 1'b1;
        if (!cnt[4]) begin
          hdr <= hdr_nxt;
          if (cnt == 5'd15) begin
            rd_act <= hit & hdr_nxt[7];
            wr_act <= hit & ~hdr_nxt[7];
            rd_req <= hit & hdr_nxt[7];
            rd_cmd <= hdr_nxt[7:0];
          end
        end else begin
          dsh <= {dsh[14:0], din};
          if (rd_act) begin
            bus_dat_o <= rsh[15];
            rsh       <= {rsh[14:0], 1'b0};
          end
          if (cnt == 5'd31) begin
            wr_valid <= wr_act;
            wr_cmd   <= hdr[7:0];
            wr_data  <= {dsh[14:0], din};
            wr_act   <= 1'b0;
          end
        end
      end else if (fall && cnt == 5'd0) begin
        rd_act <= 1'b0;
      end
    end
  end
endmodule

module pkt_bus_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rise,
  input logic       wr_valid,
  input logic       rd_req,
  input logic [7:0] rd_cmd,
  input logic       oe,
  input logic       dat_o
);
  // R3
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_valid |=> !wr_valid);
  // R5
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> !rd_req);
  // R5
  rd_cmd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> rd_cmd[7]);
  // R6
  oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(oe) |-> rd_req);
  // R6
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe) && !$stable(dat_o)) |-> $past(rise));
  // R8
  wr_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_valid |-> !oe);
endmodule

bind pkt_bus_slave pkt_bus_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .wr_valid(wr_valid), .rd_req(rd_req),
  .rd_cmd(rd_cmd), .oe(bus_dat_oe), .dat_o(bus_dat_o)
);

// File: tb/pkt_bus_slave_bench.sv
module pkt_bus_slave_bench;
  logic clk = 0, rst_n = 0, bus_clk = 0, bus_dat_i = 0;
  logic bus_dat_o, bus_dat_oe, rd_req, wr_valid;
  logic [7:0] rd_cmd, wr_cmd;
  logic [15:0] rd_data, wr_data;
  int total = 0, bad = 0;
  int wr_n = 0, rd_n = 0, oe_hi = 0;
  logic [7:0] last_wcmd, last_rcmd;
  logic [15:0] last_wdata;

  localparam logic [7:0] ME = 8'h5A;

  always #2 clk = ~clk;

  pkt_bus_slave u_pkt_bus_slave (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_dat_i(bus_dat_i),
    .bus_dat_o(bus_dat_o), .bus_dat_oe(bus_dat_oe), .rd_req(rd_req), .rd_cmd(rd_cmd),
    .rd_data(rd_data), .wr_valid(wr_valid), .wr_cmd(wr_cmd), .wr_data(wr_data));

  function automatic logic [15:0] reply(input logic [7:0] c);
    return {c, ~c} ^ 16'hC3A5;
  endfunction
  assign rd_data = reply(rd_cmd);

  always @(negedge clk) begin
    if (wr_valid) begin wr_n++; last_wcmd = wr_cmd; last_wdata = wr_data; end
    if (rd_req) begin rd_n++; last_rcmd = rd_cmd; end
    if (bus_dat_oe) oe_hi++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic send(input logic [31:0] v, input int n, output logic [15:0] rb);
    rb = '0;
    for (int i = 0; i < n; i++) begin
      bus_dat_i = v[31-i]; wt(8);
      bus_clk = 1; wt(8);
      if (i >= 16) rb[31-i] = bus_dat_o;
      bus_clk = 0; wt(8);
    end
  endtask

  logic [15:0] rb;
  int w0, r0, o0;

  initial begin
    fork
      begin #700000; chk(0, "watchdog", 0, 1); $display("test done: total=%0d bad=%0d", total, bad); $finish; end
    join_none
    wt(3);
    // R1
    chk(!bus_dat_oe && !wr_valid && !rd_req, "R1 reset", {bus_dat_oe, wr_valid, rd_req}, 0);
    rst_n = 1; wt(4);
    // R2 R3 R8: walking-one data sweep
    for (int b = 0; b < 16; b++) begin
      logic [7:0] c = 8'(b * 5);
      logic [15:0] d = 16'(1) << b;
      w0 = wr_n; o0 = oe_hi;
      send({ME, c, d}, 32, rb);
      chk(wr_n == w0 + 1, "R3 strobe count", wr_n - w0, 1);
      chk(last_wdata == d && last_wcmd == c, "R2 write fields", {last_wcmd, last_wdata}, {c, d});
      chk(oe_hi == o0, "R8 no drive", oe_hi - o0, 0);
    end
    // R5 R6: reads
    for (int k = 0; k < 8; k++) begin
      logic [7:0] c = 8'h80 | 8'(k * 17);
      r0 = rd_n;
      send({ME, c, 16'hFFFF}, 32, rb);
      chk(rd_n == r0 + 1 && last_rcmd == c, "R5 read request", last_rcmd, c);
      chk(rb == reply(c), "R6 read data", rb, reply(c));
      chk(!bus_dat_oe, "R6 release", bus_dat_oe, 0);
    end
    // R4: foreign addresses, both directions
    for (int k = 0; k < 6; k++) begin
      logic [7:0] a = ME ^ (8'(1) << k);
      w0 = wr_n; r0 = rd_n; o0 = oe_hi;
      send({a, 8'(k[0] ? 8'h85 : 8'h05), 16'hA5A5}, 32, rb);
      chk(wr_n == w0 && rd_n == r0 && oe_hi == o0, "R4 ignored", (wr_n - w0) + (rd_n - r0) + (oe_hi - o0), 0);
    end
    // R7: cut-off write then clean write
    send({ME, 8'h11, 16'h0}, 11, rb);
    wt(100);
    w0 = wr_n;
    send({ME, 8'h22, 16'hBEEF}, 32, rb);
    chk(wr_n == w0 + 1 && last_wdata == 16'hBEEF && last_wcmd == 8'h22, "R7 realign write", last_wdata, 16'hBEEF);
    // R7: stall mid read
    send({ME, 8'h9C, 16'h0}, 20, rb);
    chk(bus_dat_oe, "R6 driving mid read", bus_dat_oe, 1);
    wt(100);
    chk(!bus_dat_oe, "R7 release on idle", bus_dat_oe, 1'b0);
    send({ME, 8'hC1, 16'h0}, 32, rb);
    chk(rb == reply(8'hC1), "R7 read after resync", rb, reply(8'hC1));
    w0 = wr_n;
    send({ME, 8'h33, 16'h1234}, 32, rb);
    chk(wr_n == w0 + 1 && last_wdata == 16'h1234, "R3 write after read", last_wdata, 16'h1234);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule